// File: doc/BRIEF.md
# Register-form stack operand checker

This block sits in the decode path of a floating-point unit with an eight-register stack. It receives an escape byte (0xD8 to 0xDF) and a ModR/M byte whose mode field is 3, so the operand is a stack register and not memory. From the register-field bits of ModR/M and the low three bits of the escape byte it builds a 6-bit dispatch index. It then looks up which stack operands that instruction needs.

It reads the 2-bit tags of ST(0) and ST(i) from a 16-bit tag word. The tags are located relative to the current top-of-stack pointer. The block then returns a single verdict: go ahead, one of three underflow flavours, or illegal opcode. The index and the verdict appear together, one cycle after the request, with a valid strobe. The execution stage uses the verdict to choose between running the operation and taking the matching stack-fault path.

Top module: `fpstk_opcheck`

## Requirements
- R1: `out_index` equals `{modrm[5:3], esc_byte[2:0]}` of the request that produced it. Below, "reg" means `modrm[5:3]` and "i" means `modrm[2:0]`.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and only then. While `rst_n` is low, all outputs are 0.
- R3: Every index not named in R4 to R8 gives result code 0 (proceed), whatever the tags hold.
- R4: The ST(0)-only entries are escape D9 reg 3, DD reg 2 and 3, and DF reg 2 and 3. They give code 1 (underflow) when ST(0) is empty, otherwise 0.
- R5: The two-operand entries are D8 reg 0, 1 and 4 to 7, DD reg 1, and DF reg 1. They give code 1 when ST(0) or ST(i) is empty, otherwise 0.
- R6: The result-to-ST(i) entries are DC reg 0, 1 and 4 to 7. They give code 2 (underflow aimed at ST(i)) when ST(0) or ST(i) is empty, otherwise 0.
- R7: The result-then-pop entries are DE reg 0, 1 and 4 to 7. They give code 3 (underflow with pop) when ST(0) or ST(i) is empty, otherwise 0.
- R8: DA reg 4, 6 and 7, DB reg 7, DD reg 6 and 7, and DF reg 7 give code 4 (illegal), whatever the tags hold.
- R9: ST(k) lives in physical slot `(top_ptr + k) mod 8`. Its tag is `tag_word[2n+1:2n]` for slot n, and tag value 3 means empty. The slot number wraps past 7.
- R10: Code 7 (internal error) is reserved for a table class outside the defined set and never appears for any of the 64 indices.
- R11: When i is 0, ST(i) is ST(0), so only the ST(0) tag decides the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| esc_byte | input | 8 | Escape opcode byte, 0xD8 to 0xDF |
| modrm | input | 8 | ModR/M byte, mode field 3 |
| tag_word | input | 16 | Eight 2-bit tags, slot n at bits [2n+1:2n] |
| top_ptr | input | 3 | Physical slot of ST(0) |
| out_valid | output | 1 | Verdict strobe, one cycle after the request |
| out_result | output | 3 | Verdict code (0 to 4, 7) |
| out_index | output | 6 | Dispatch index of the request |

## Verification
The assertions take for granted that every request carries an escape byte whose upper five bits are 11011 and a ModR/M byte whose mode field is 3. One property states this input contract outright. The stimulus keeps to it: the bench builds every escape byte as 0xD8 plus a 3-bit column and every ModR/M as 0xC0 plus the register and rm fields. It sweeps all 64 indices against empty, full and random tag words with random top and rm. The directed cases cover wrap-around slot lookup and i equal to 0.

// File: rtl/fpstk_opcheck_pkg.sv
package fpstk_opcheck_pkg;

  typedef enum logic [2:0] {
    CK_NONE     = 3'd0,
    CK_ST0      = 3'd1,
    CK_BOTH     = 3'd2,
    CK_BOTH_TOI = 3'd3,
    CK_BOTH_POP = 3'd4,
    CK_ILLEGAL  = 3'd5
  } chk_class_e;

  typedef enum logic [2:0] {
    RS_PROCEED   = 3'd0,
    RS_UNDERFLOW = 3'd1,
    RS_UNDER_STI = 3'd2,
    RS_UNDER_POP = 3'd3,
    RS_ILLEGAL   = 3'd4,
    RS_INTERNAL  = 3'd7
  } chk_result_e;

  function automatic logic [5:0] form_index(input logic [2:0] reg_f,
                                            input logic [2:0] esc_lo);
    return {reg_f, esc_lo};
  endfunction

  // Class of an index: row = ModR/M reg field, column = escape low bits.
  function automatic chk_class_e class_of(input logic [5:0] idx);
    logic [2:0] row;
    logic [2:0] col;
    logic       mid;
    chk_class_e c;
    row = idx[5:3];
    col = idx[2:0];
    mid = (row == 3'd2) || (row == 3'd3);
    c   = CK_NONE;
    case (col)
      3'd0: c = mid ? CK_NONE : CK_BOTH;
      3'd1: c = (row == 3'd3) ? CK_ST0 : CK_NONE;
      3'd2: c = (row == 3'd4 || row == 3'd6 || row == 3'd7) ? CK_ILLEGAL : CK_NONE;
      3'd3: c = (row == 3'd7) ? CK_ILLEGAL : CK_NONE;
      3'd4: c = mid ? CK_NONE : CK_BOTH_TOI;
      3'd5: begin
        if (row == 3'd1)                     c = CK_BOTH;
        else if (mid)                        c = CK_ST0;
        else if (row == 3'd6 || row == 3'd7) c = CK_ILLEGAL;
        else                                 c = CK_NONE;
      end
      3'd6: c = mid ? CK_NONE : CK_BOTH_POP;
      default: begin
        if (row == 3'd1)      c = CK_BOTH;
        else if (mid)         c = CK_ST0;
        else if (row == 3'd7) c = CK_ILLEGAL;
        else                  c = CK_NONE;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fpstk_op_lut.sv
module fpstk_op_lut
  import fpstk_opcheck_pkg::*;
(
  input  logic [2:0] esc_lo,
  input  logic [2:0] reg_f,
  output logic [5:0] idx,
  output chk_class_e cls
);
  always_comb begin
    idx = form_index(reg_f, esc_lo);
    cls = class_of(idx);
  end
endmodule

// File: rtl/fpstk_slot_probe.sv
module fpstk_slot_probe #(
  parameter int SLOTS = 8,
  parameter int TAG_W = 2,
  parameter logic [TAG_W-1:0] EMPTY_TAG = '1,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int TW_W  = SLOTS * TAG_W
) (
  input  logic [TW_W-1:0]  tag_word,
  input  logic [PTR_W-1:0] top_ptr,
  input  logic [PTR_W-1:0] reg_sel,
  output logic [PTR_W-1:0] phys_slot,
  output logic             is_empty
);
  logic [TAG_W-1:0] tag_val;
  always_comb begin
    phys_slot = top_ptr + reg_sel;
    tag_val   = tag_word[int'(phys_slot) * TAG_W +: TAG_W];
    is_empty  = (tag_val == EMPTY_TAG);
  end
endmodule

// File: rtl/fpstk_verdict.sv
module fpstk_verdict
  import fpstk_opcheck_pkg::*;
(
  input  chk_class_e  cls,
  input  logic        st0_empty,
  input  logic        sti_empty,
  output chk_result_e verdict
);
  logic any_empty;
  always_comb begin
    any_empty = st0_empty || sti_empty;
    case (cls)
      CK_NONE:     verdict = RS_PROCEED;
      CK_ST0:      verdict = st0_empty ? RS_UNDERFLOW : RS_PROCEED;
      CK_BOTH:     verdict = any_empty ? RS_UNDERFLOW : RS_PROCEED;
      CK_BOTH_TOI: verdict = any_empty ? RS_UNDER_STI : RS_PROCEED;
      CK_BOTH_POP: verdict = any_empty ? RS_UNDER_POP : RS_PROCEED;
      CK_ILLEGAL:  verdict = RS_ILLEGAL;
      default:     verdict = RS_INTERNAL;
    endcase
  end
endmodule

// File: rtl/fpstk_opcheck.sv
module fpstk_opcheck
  import fpstk_opcheck_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int TAG_W = 2,
  parameter logic [TAG_W-1:0] EMPTY_TAG = '1,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int TW_W  = SLOTS * TAG_W,
  localparam int NPROBE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       esc_byte,
  input  logic [7:0]       modrm,
  input  logic [TW_W-1:0]  tag_word,
  input  logic [PTR_W-1:0] top_ptr,
  output logic             out_valid,
  output logic [2:0]       out_result,
  output logic [5:0]       out_index
);

  logic [5:0]       idx_w;
  chk_class_e       cls_w;
  chk_result_e      verdict_w;
  logic [2:0]       cls_bits;
  logic             st0_empty;
  logic             sti_empty;
  logic [PTR_W-1:0] probe_sel  [NPROBE];
  logic [PTR_W-1:0] probe_slot [NPROBE];
  logic             probe_empty[NPROBE];

  fpstk_op_lut u_lut (
    .esc_lo (esc_byte[2:0]),
    .reg_f  (modrm[5:3]),
    .idx    (idx_w),
    .cls    (cls_w)
  );

  // probe 0 reads ST(0), probe 1 reads ST(i)
  assign probe_sel[0] = '0;
  assign probe_sel[1] = PTR_W'(modrm[2:0]);

  for (genvar g = 0; g < NPROBE; g++) begin : g_probe
    fpstk_slot_probe #(
      .SLOTS     (SLOTS),
      .TAG_W     (TAG_W),
      .EMPTY_TAG (EMPTY_TAG)
    ) u_probe (
      .tag_word  (tag_word),
      .top_ptr   (top_ptr),
      .reg_sel   (probe_sel[g]),
      .phys_slot (probe_slot[g]),
      .is_empty  (probe_empty[g])
    );
  end

  assign st0_empty = probe_empty[0];
  assign sti_empty = probe_empty[1];
  assign cls_bits  = cls_w;

  fpstk_verdict u_verdict (
    .cls       (cls_w),
    .st0_empty (st0_empty),
    .sti_empty (sti_empty),
    .verdict   (verdict_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_index  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= verdict_w;
        out_index  <= idx_w;
      end
    end
  end

endmodule

module fpstk_opcheck_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] esc_byte,
  input logic [7:0] modrm,
  input logic       out_valid,
  input logic [2:0] out_result,
  input logic [5:0] out_index,
  input logic [2:0] cls,
  input logic       st0_empty,
  input logic       sti_empty
);
  // input contract: register-form request from the escape range
  a_r1_in_form: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (esc_byte[7:3] == 5'b11011 && modrm[7:6] == 2'b11));

  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r1_index: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_index == $past({modrm[5:3], esc_byte[2:0]}));

  a_r3_none_proceeds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == 3'd0) |=> out_result == 3'd0);

  a_r4_st0_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == 3'd1 && st0_empty) |=> out_result == 3'd1);

  a_r5_full_proceeds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !st0_empty && !sti_empty && cls != 3'd5) |=> out_result == 3'd0);

  a_r6_toi_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == 3'd3 && (st0_empty || sti_empty)) |=> out_result == 3'd2);

  a_r7_pop_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == 3'd4 && (st0_empty || sti_empty)) |=> out_result == 3'd3);

  a_r8_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls == 3'd5) |=> out_result == 3'd4);

  a_r10_no_internal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_result != 3'd7);
endmodule

bind fpstk_opcheck fpstk_opcheck_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .esc_byte   (esc_byte),
  .modrm      (modrm),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_index  (out_index),
  .cls        (cls_bits),
  .st0_empty  (st0_empty),
  .sti_empty  (sti_empty)
);

// File: tb/fpstk_opcheck_bench.sv
`timescale 1ns/1ps
module fpstk_opcheck_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  esc_byte = 8'hD8;
  logic [7:0]  modrm = 8'hC0;
  logic [15:0] tag_word = '0;
  logic [2:0]  top_ptr = '0;
  logic        out_valid;
  logic [2:0]  out_result;
  logic [5:0]  out_index;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] res;
    logic [5:0] idx;
    string      req;
  } exp_t;
  exp_t q[$];

  // per escape column, one letter per reg row 0..7
  // N none, S st0 only, B both, T to ST(i), P pop, I illegal
  string cls_rows [8] = '{"BBNNBBBB", "NNNSNNNN", "NNNNINII", "NNNNNNNI",
                          "TTNNTTTT", "NBSSNNII", "PPNNPPPP", "NBSSNNNI"};

  always #4 clk = ~clk;

  fpstk_opcheck u_fpstk_opcheck (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .esc_byte   (esc_byte),
    .modrm      (modrm),
    .tag_word   (tag_word),
    .top_ptr    (top_ptr),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_index  (out_index)
  );

  function automatic bit slot_empty(input logic [15:0] tw, input int phys);
    return ((tw >> (2 * (phys % 8))) & 16'd3) == 16'd3;
  endfunction

  function automatic byte letter(input int col, input int rw);
    string s;
    s = cls_rows[col];
    return s.getc(rw);
  endfunction

  function automatic string req_of(input byte ch);
    case (ch)
      "S": return "R4";
      "B": return "R5";
      "T": return "R6";
      "P": return "R7";
      "I": return "R8";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [2:0] model(input int col, input int rw, input int rm,
                                      input int top, input logic [15:0] tw);
    bit e0, ei;
    byte ch;
    e0 = slot_empty(tw, top);
    ei = slot_empty(tw, top + rm);
    ch = letter(col, rw);
    case (ch)
      "S": return e0 ? 3'd1 : 3'd0;
      "B": return (e0 || ei) ? 3'd1 : 3'd0;
      "T": return (e0 || ei) ? 3'd2 : 3'd0;
      "P": return (e0 || ei) ? 3'd3 : 3'd0;
      "I": return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  task automatic send(input int col, input int rw, input int rm, input int top,
                      input logic [15:0] tw, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    esc_byte = 8'hD8 + 8'(col);
    modrm    = 8'hC0 | 8'(rw << 3) | 8'(rm);
    tag_word = tw;
    top_ptr  = 3'(top);
    e.res = model(col, rw, rm, top, tw);
    e.idx = 6'(rw * 8 + col);
    e.req = (tag == "") ? req_of(letter(col, rw)) : tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected out_valid: actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (out_result !== e.res) begin
          bad++;
          $display("FAIL %s result idx=%0d: actual=%0d expected=%0d",
                   e.req, e.idx, out_result, e.res);
        end
        total++;
        if (out_index !== e.idx) begin
          bad++;
          $display("FAIL R1 index: actual=%0d expected=%0d", out_index, e.idx);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    total++;
    if (out_valid !== 1'b0 || out_result !== 3'd0 || out_index !== 6'd0) begin
      bad++;
      $display("FAIL R2 reset outputs: actual=%0b/%0d/%0d expected=0/0/0",
               out_valid, out_result, out_index);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    for (int rw = 0; rw < 8; rw++) begin
      for (int col = 0; col < 8; col++) begin
        send(col, rw, 5, 2, 16'h0000, "");
        send(col, rw, 5, 2, 16'hFFFF, "");
        send(col, rw, 3, 4, 16'h0003 << 8, "");   // only ST(0) (slot 4) empty
        send(col, rw, 3, 4, 16'h0003 << 14, "");  // only ST(3) (slot 7) empty
        for (int p = 0; p < 3; p++)
          send(col, rw, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
               16'($urandom), "");
      end
      idle(1);
    end

    // R9 wrap: top 6, i 3 -> slot 1; only slot 1 empty
    send(0, 0, 3, 6, 16'h000C, "R9");
    send(4, 0, 3, 6, 16'h000C, "R9");
    send(6, 1, 3, 6, 16'h000C, "R9");
    // R9: slot 1 full, slot 9 unwrapped would be out of range; all else empty
    send(0, 0, 3, 6, 16'hFFF3 & 16'hFFF3, "R9");
    send(0, 0, 3, 6, 16'h0C00 | 16'h0000, "R9");
    // R11: i = 0, ST(0) full
    send(4, 4, 0, 5, 16'hF3FF, "R11");
    // R11: i = 0, ST(0) empty, others full
    send(6, 4, 0, 5, 16'h0C00, "R11");
    send(0, 5, 0, 0, 16'hFFFC, "R11");
    // R10: defined indices never yield code 7 (model never expects 7)
    send(5, 7, 1, 1, 16'h5555, "R10");
    send(1, 3, 2, 3, 16'h00C0, "R10");
    idle(4);

    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R2 missing results: actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule